// File: doc/BRIEF.md
# Local interrupt priority selector

This block decides which local interrupt a hart takes at this moment, or that it takes none. It combines the pending and enable vectors with the delegation mask, the current privilege level and the global machine, supervisor and hypervisor-supervisor enable bits. Its outputs are a valid flag, the index of the chosen interrupt and a flag that sends the trap to the hypervisor level. The logic is purely combinational, so the outputs follow any input change within the same cycle.

There is no data stream at its edge. Every pin is a plain level, with no valid/ready handshake and no back-pressure. The trap-entry logic samples the outputs when it is ready to act. When `virt_mode` is high, interrupts that are not guest interrupts are checked first under the hypervisor-supervisor enable. A winner there raises `force_hyp`. Only when that path finds nothing do the guest interrupt bits take part, under the normal gating. The parameter `HYP_EN` removes the hypervisor path altogether.

Top module: `irq_priority_select`

## Requirements
- R1: An interrupt is a candidate only when its bit is set in both `irq_pending` and `irq_enable`. With no candidate, `take_valid` is 0.
- R2: A candidate whose `irq_deleg` bit is 0 is taken only when `cur_priv` is below M, or when `cur_priv` is M and `m_gie` is 1. The privilege encoding is U=0, S=1, M=3.
- R3: A candidate whose `irq_deleg` bit is 1 is taken only when `cur_priv` is U, or when `cur_priv` is S and `s_gie` is 1. At M it is never taken.
- R4: Among the candidates that pass gating, the one with the lowest bit index is reported on `take_index`. Gating is applied before priority, so a gated-off lower bit does not hide a higher one.
- R5: When nothing is taken, `take_valid` is 0, `take_index` is 0 and `force_hyp` is 0.
- R6: With `virt_mode` at 1, candidates outside the guest bits (2, 6 and 10 by default) are gated only by the hypervisor enable, whatever their delegation bit. That enable is open when `cur_priv` is U, or S with `hs_gie` at 1. If any such candidate exists, the lowest one is taken with `force_hyp` at 1, even when a lower-numbered guest candidate exists.
- R7: With `virt_mode` at 1 and no candidate from R6, only the guest bits are considered, under the gating of R2 and R3. Non-guest candidates are ignored and `force_hyp` is 0.
- R8: With `virt_mode` at 0, `hs_gie` has no effect and `force_hyp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irq_pending | input | 16 | Pending interrupt bits |
| irq_enable | input | 16 | Per-interrupt enable bits |
| irq_deleg | input | 16 | Delegation mask, 1 = delegated to supervisor |
| cur_priv | input | 2 | Current privilege, U=0, S=1, M=3 |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| virt_mode | input | 1 | Hart runs in virtual (guest) mode |
| hs_gie | input | 1 | Hypervisor-level supervisor global enable |
| take_valid | output | 1 | An interrupt is taken |
| take_index | output | 4 | Index of the taken interrupt |
| force_hyp | output | 1 | Taken interrupt must trap to the hypervisor level |

## Verification
In virtual mode, hypervisor pre-emption and guest selection can apply to the same input word. The bench provokes this by pending a guest bit below a non-guest bit with both enabled. It judges the result by `force_hyp` and by which of the two indices comes out. The same pattern is then repeated with `hs_gie` closed, and the guest bit must win with `force_hyp` low. A seeded sweep over random vectors compares every output with a model written from the requirements.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/irq_gate_en.sv
module irq_gate_en
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       m_gie,
  input  logic       s_gie,
  input  logic       hs_gie,
  output logic       m_open,
  output logic       s_open,
  output logic       hs_open
);
  // A level is open when running below it, or at it with its enable set.
  always_comb begin
    m_open  = (priv < PRIV_M) || ((priv == PRIV_M) && m_gie);
    s_open  = (priv < PRIV_S) || ((priv == PRIV_S) && s_gie);
    hs_open = (priv < PRIV_S) || ((priv == PRIV_S) && hs_gie);
  end
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int WIDTH = 16,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [WIDTH:0]   below;
  logic [WIDTH-1:0] first;

  assign below[0] = 1'b0;

  // Prefix chain: a bit wins when no lower bit is set.
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_chain
      assign first[g]     = vec[g] & ~below[g];
      assign below[g + 1] = below[g] | vec[g];
    end
  endgenerate

  assign any = below[WIDTH];

  always_comb begin
    idx = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (first[k]) idx = idx | IDX_W'(k);
    end
  end
endmodule

// File: rtl/irq_priority_select.sv
module irq_priority_select #(
  parameter int              NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0] GUEST_MASK = 16'h0444,
  parameter bit              HYP_EN     = 1'b1,
  localparam int             IDX_W      = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_IRQ-1:0] irq_deleg,
  input  logic [1:0]         cur_priv,
  input  logic               m_gie,
  input  logic               s_gie,
  input  logic               virt_mode,
  input  logic               hs_gie,
  output logic               take_valid,
  output logic [IDX_W-1:0]   take_index,
  output logic               force_hyp
);
  logic               m_open, s_open, hs_open;
  logic [NUM_IRQ-1:0] cand;
  logic [NUM_IRQ-1:0] base_cand;
  logic [NUM_IRQ-1:0] norm_sel;
  logic               norm_any;
  logic [IDX_W-1:0]   norm_idx;
  logic               hs_any;
  logic [IDX_W-1:0]   hs_idx;

  irq_gate_en u_gate (
    .priv    (cur_priv),
    .m_gie   (m_gie),
    .s_gie   (s_gie),
    .hs_gie  (hs_gie),
    .m_open  (m_open),
    .s_open  (s_open),
    .hs_open (hs_open)
  );

  assign cand = irq_pending & irq_enable;

  generate
    if (HYP_EN) begin : g_hyp
      logic [NUM_IRQ-1:0] hs_sel;
      assign hs_sel    = virt_mode ? (cand & ~GUEST_MASK & {NUM_IRQ{hs_open}}) : '0;
      assign base_cand = virt_mode ? (cand & GUEST_MASK) : cand;

      irq_lsb_pick #(.WIDTH(NUM_IRQ)) u_hs_pick (
        .vec (hs_sel),
        .any (hs_any),
        .idx (hs_idx)
      );
    end else begin : g_nohyp
      logic unused_hyp;
      assign unused_hyp = virt_mode ^ hs_open;
      assign hs_any     = 1'b0;
      assign hs_idx     = '0;
      assign base_cand  = cand;
    end
  endgenerate

  // Delegation chooses which global enable gates each candidate.
  assign norm_sel = (base_cand & ~irq_deleg & {NUM_IRQ{m_open}})
                  | (base_cand &  irq_deleg & {NUM_IRQ{s_open}});

  irq_lsb_pick #(.WIDTH(NUM_IRQ)) u_norm_pick (
    .vec (norm_sel),
    .any (norm_any),
    .idx (norm_idx)
  );

  always_comb begin
    if (hs_any) begin
      take_valid = 1'b1;
      take_index = hs_idx;
      force_hyp  = 1'b1;
    end else begin
      take_valid = norm_any;
      take_index = norm_any ? norm_idx : '0;
      force_hyp  = 1'b0;
    end
  end
endmodule

// File: rtl/irq_priority_select_chk.sv
module irq_priority_select_chk #(
  parameter int NUM_IRQ = 16,
  parameter logic [NUM_IRQ-1:0] GUEST_MASK = 16'h0444,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input logic [NUM_IRQ-1:0] irq_pending,
  input logic [NUM_IRQ-1:0] irq_enable,
  input logic [NUM_IRQ-1:0] irq_deleg,
  input logic [1:0]         cur_priv,
  input logic               m_gie,
  input logic               s_gie,
  input logic               virt_mode,
  input logic               hs_gie,
  input logic               take_valid,
  input logic [IDX_W-1:0]   take_index,
  input logic               force_hyp
);
  logic [NUM_IRQ-1:0] cand;
  assign cand = irq_pending & irq_enable;

  always_comb begin
    // R1
    no_cand_idle_chk: assert ((cand != '0) || !take_valid)
      else $error("taken with no candidate");
    // R4
    winner_is_cand_chk: assert (!take_valid || cand[take_index])
      else $error("winner not a candidate");
    // R2
    m_closed_chk: assert (!((cur_priv == 2'd3) && !m_gie && !virt_mode) || !take_valid)
      else $error("taken at M with machine enable clear");
    // R3
    deleg_gate_chk: assert (!(take_valid && !force_hyp && irq_deleg[take_index])
                            || (cur_priv == 2'd0) || ((cur_priv == 2'd1) && s_gie))
      else $error("delegated taken while supervisor closed");
    // R5
    idle_zero_chk: assert (take_valid || ((take_index == '0) && !force_hyp))
      else $error("idle outputs not zero");
    // R6
    force_nonguest_chk: assert (!force_hyp || (virt_mode && take_valid && !GUEST_MASK[take_index]))
      else $error("force flag on guest or outside virtual mode");
    // R7
    guest_only_chk: assert (!(virt_mode && take_valid && !force_hyp) || GUEST_MASK[take_index])
      else $error("non-guest taken without force in virtual mode");
    // R8
    no_force_native_chk: assert (virt_mode || !force_hyp)
      else $error("force flag outside virtual mode");
  end
endmodule

bind irq_priority_select irq_priority_select_chk #(
  .NUM_IRQ    (NUM_IRQ),
  .GUEST_MASK (GUEST_MASK)
) u_chk (
  .irq_pending (irq_pending),
  .irq_enable  (irq_enable),
  .irq_deleg   (irq_deleg),
  .cur_priv    (cur_priv),
  .m_gie       (m_gie),
  .s_gie       (s_gie),
  .virt_mode   (virt_mode),
  .hs_gie      (hs_gie),
  .take_valid  (take_valid),
  .take_index  (take_index),
  .force_hyp   (force_hyp)
);

// File: tb/sim_irq_priority_select.sv
module sim_irq_priority_select;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  localparam logic [15:0] GMASK = 16'h0444;

  typedef struct packed {
    logic [15:0] p;
    logic [15:0] e;
    logic [15:0] d;
    logic [1:0]  pr;
    logic        mg;
    logic        sg;
    logic        v;
    logic        hg;
    logic        ev;
    logic [3:0]  ei;
    logic        ef;
    logic [7:0]  rq;
  } vec_t;

  // Fields: pending, enable, deleg, priv, m_gie, s_gie, virt, hs_gie, exp valid, exp index, exp force, req
  localparam vec_t TBL [NV] = '{
    '{16'h0080, 16'h0000, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 8'd1}, // R1
    '{16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7,  1'b0, 8'd2}, // R2
    '{16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 8'd2}, // R2
    '{16'h0080, 16'h0080, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7,  1'b0, 8'd2}, // R2
    '{16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5,  1'b0, 8'd3}, // R3
    '{16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 8'd3}, // R3
    '{16'h0020, 16'h0020, 16'h0020, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5,  1'b0, 8'd3}, // R3
    '{16'h0020, 16'h0020, 16'h0020, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 8'd3}, // R3
    '{16'h0aa0, 16'h0ff0, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5,  1'b0, 8'd4}, // R4
    '{16'h00a0, 16'hffff, 16'h0020, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7,  1'b0, 8'd4}, // R4
    '{16'hffff, 16'h8000, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0, 8'd4}, // R4
    '{16'h0088, 16'hffff, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3,  1'b1, 8'd6}, // R6
    '{16'h0084, 16'hffff, 16'h0004, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd7,  1'b1, 8'd6}, // R6
    '{16'h0010, 16'hffff, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4,  1'b1, 8'd6}, // R6
    '{16'h0084, 16'hffff, 16'h0004, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2,  1'b0, 8'd7}, // R7
    '{16'h0080, 16'hffff, 16'h0000, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 8'd7}, // R7
    '{16'h0440, 16'hffff, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6,  1'b0, 8'd7}, // R7
    '{16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 8'd8}  // R8
  };

  logic        clk = 1'b0;
  logic [15:0] irq_pending, irq_enable, irq_deleg;
  logic [1:0]  cur_priv;
  logic        m_gie, s_gie, virt_mode, hs_gie;
  logic        take_valid, force_hyp;
  logic [3:0]  take_index;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_priority_select u0 (
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .irq_deleg   (irq_deleg),
    .cur_priv    (cur_priv),
    .m_gie       (m_gie),
    .s_gie       (s_gie),
    .virt_mode   (virt_mode),
    .hs_gie      (hs_gie),
    .take_valid  (take_valid),
    .take_index  (take_index),
    .force_hyp   (force_hyp)
  );

  task automatic drive(input vec_t t);
    @(negedge clk);
    irq_pending = t.p;
    irq_enable  = t.e;
    irq_deleg   = t.d;
    cur_priv    = t.pr;
    m_gie       = t.mg;
    s_gie       = t.sg;
    virt_mode   = t.v;
    hs_gie      = t.hg;
    #2;
  endtask

  task automatic check(input string rq, input logic ev, input logic [3:0] ei, input logic ef);
    checks++;
    if (take_valid !== ev || take_index !== ei || force_hyp !== ef) begin
      failures++;
      $display("FAIL %s actual valid=%0b idx=%0d force=%0b expected valid=%0b idx=%0d force=%0b",
               rq, take_valid, take_index, force_hyp, ev, ei, ef);
    end
  endtask

  // Lowest set bit of a vector; returns 0 when empty.
  function automatic logic [3:0] lowest(input logic [15:0] x);
    for (int k = 0; k < 16; k++) if (x[k]) return 4'(k);
    return 4'd0;
  endfunction

  // Expected outputs built from R1..R8.
  function automatic logic [5:0] model(input vec_t t);
    logic [15:0] c, hs, sel;
    logic mo, so, ho;
    c  = t.p & t.e;
    mo = (t.pr != 2'd3) || t.mg;
    so = (t.pr == 2'd0) || ((t.pr == 2'd1) && t.sg);
    ho = (t.pr == 2'd0) || ((t.pr == 2'd1) && t.hg);
    if (t.v) begin
      hs = ho ? (c & ~GMASK) : 16'h0;
      if (hs != 16'h0) return {1'b1, lowest(hs), 1'b1};
      c = c & GMASK;
    end
    sel = 16'h0;
    for (int k = 0; k < 16; k++)
      if (c[k]) sel[k] = t.d[k] ? so : mo;
    return {sel != 16'h0, lowest(sel), 1'b0};
  endfunction

  initial begin
    vec_t z;
    vec_t r;
    logic [5:0] m;
    z = '0;
    drive(z);
    check("R5", 1'b0, 4'd0, 1'b0); // idle state after all-zero inputs

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check($sformatf("R%0d", TBL[i].rq), TBL[i].ev, TBL[i].ei, TBL[i].ef);
    end

    // R5: idle after a taken interrupt leaves no stale index
    r = TBL[10];
    drive(r);
    r.e = 16'h0;
    drive(r);
    check("R5", 1'b0, 4'd0, 1'b0);

    // R8: hs_gie toggled in native mode changes nothing
    r = TBL[3];
    r.hg = 1'b1;
    drive(r);
    check("R8", 1'b1, 4'd7, 1'b0);

    // R4: seeded sweep against the requirement model
    for (int n = 0; n < 400; n++) begin
      r.p  = 16'($urandom);
      r.e  = 16'($urandom);
      r.d  = 16'($urandom);
      r.pr = (n % 3 == 0) ? 2'd0 : ((n % 3 == 1) ? 2'd1 : 2'd3);
      r.mg = 1'($urandom);
      r.sg = 1'($urandom);
      r.v  = 1'($urandom);
      r.hg = 1'($urandom);
      drive(r);
      m = model(r);
      check("R4", m[5], m[4:1], m[0]);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule